// File: doc/BRIEF.md
# Masked Vector Lane Writeback

This block sits on both sides of a bank of per-lane compute units that work on a wide vector of 32-bit elements. On the way in, it picks the operand each lane gets: normally the lane's own element of the source vector, or, when the source came from memory and a broadcast is requested, element 0 copied to every lane. It also tells each compute lane whether it is active, so that lanes that will not be written stay idle and cannot report exceptions.

On the way out, it builds the new destination vector when the lane results are flagged valid. A write mask picks which lanes take their computed result. Lanes not picked either keep the old destination value (merging) or are cleared (zeroing). When masking is switched off, every lane is written. The per-lane exception flags from the active lanes are ORed into one summary flag per exception type. These flags are registered together with the destination.

Top module: `vec_lane_writeback`

## Requirements
- R1: Lane j of every vector port occupies bits [32j+31:32j], so lane 0 is the least significant word.
- R2: When `mask_en` is 0, a cycle with `res_valid` high writes every lane of `dst_out` with its lane result, whatever `wmask` and `zero_mode` hold.
- R3: When `mask_en` is 1 and `wmask[j]` is 1, a `res_valid` cycle writes lane j of `dst_out` with lane j of `lane_res`.
- R4: When `mask_en` is 1, `zero_mode` is 0 and `wmask[j]` is 0, a `res_valid` cycle writes lane j of `dst_out` with lane j of `old_dst` (merging).
- R5: When `mask_en` is 1, `zero_mode` is 1 and `wmask[j]` is 0, a `res_valid` cycle writes lane j of `dst_out` with 32'h0 (zeroing).
- R6: When both `src_is_mem` and `bcast_en` are 1, every lane of `lane_opnd` equals `src_vec[31:0]`. In every other case lane j of `lane_opnd` equals lane j of `src_vec`. This path is combinational.
- R7: When `src_is_mem` is 0, `bcast_en` has no effect on `lane_opnd`.
- R8: `lane_en[j]` is 1 exactly when `mask_en` is 0 or `wmask[j]` is 1, independent of `zero_mode`. This path is combinational.
- R9: `lane_exc` holds two flags per lane, bit 2j+k being flag k of lane j. On a `res_valid` cycle, `exc_sum[k]` is loaded with the OR of flag k over the lanes whose `lane_en` is 1. Flags from disabled lanes are ignored.
- R10: `dst_out` and `exc_sum` change only one clock after a cycle with `res_valid` high, all lanes together. In all other cycles they hold their value.
- R11: A clock edge with `rst_n` low clears `dst_out` and `exc_sum` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_vec | input | 512 | Source vector, 16 lanes of 32 bits |
| src_is_mem | input | 1 | Source operand was fetched from memory |
| bcast_en | input | 1 | Request broadcast of element 0 |
| wmask | input | 16 | Per-lane write mask |
| mask_en | input | 1 | Masking active; 0 writes every lane |
| zero_mode | input | 1 | 1 clears unselected lanes, 0 keeps them |
| old_dst | input | 512 | Current destination vector |
| res_valid | input | 1 | Lane results are valid this cycle |
| lane_res | input | 512 | Per-lane computed results |
| lane_exc | input | 32 | Per-lane exception flags, two per lane |
| lane_opnd | output | 512 | Operand sent to each compute lane |
| lane_en | output | 16 | Per-lane activity enable |
| dst_out | output | 512 | Registered new destination vector |
| exc_sum | output | 2 | Registered summary exception flags |

## Verification
The writeback is driven with masking off, with half-and-half and alternating masks in both merge and zero modes, and with all-clear and all-set masks. Each of these separates the three lane outcomes (result, old value, zero) and shows that `zero_mode` only matters for unselected lanes. Operand steering is tried with broadcast requested for both memory and register sources, and without it, which shows that the broadcast needs both conditions. Idle cycles and a mid-run reset show that the output register holds or clears. Exception flags are randomised on disabled lanes to show they never reach the summary.

// File: rtl/vlw_pkg.sv
// Package: shared defaults and the lane disposition encoding used
// between the policy and merge stages of the lane writeback.
package vlw_pkg;

    localparam int DEF_LANES     = 16;
    localparam int DEF_LANE_W    = 32;
    localparam int DEF_EXC_TYPES = 2;
    localparam int DISP_W        = 2;

    // What a lane's destination word becomes on a writeback cycle.
    typedef enum logic [DISP_W-1:0] {
        LD_RESULT = 2'd0,
        LD_KEEP   = 2'd1,
        LD_CLEAR  = 2'd2
    } lane_disp_e;

endpackage

// File: rtl/vlw_operand_steer.sv
// Module: vlw_operand_steer
// Picks the operand for each compute lane. Element 0 is copied to
// all lanes only when the source came from memory and broadcast is
// requested; otherwise lanes pass straight through.
// Assumes: purely combinational, no register.
module vlw_operand_steer #(
    parameter int LANES  = vlw_pkg::DEF_LANES,
    parameter int LANE_W = vlw_pkg::DEF_LANE_W
) (
    input  logic [LANES*LANE_W-1:0] src_vec,
    input  logic                    src_is_mem,
    input  logic                    bcast_en,
    output logic [LANES*LANE_W-1:0] opnd
);

    logic do_bcast;

    // Broadcast qualifies only for a memory source.
    always_comb do_bcast = src_is_mem & bcast_en;

    genvar j;
    generate
        for (j = 0; j < LANES; j++) begin : g_lane
            // Per-lane operand select between element 0 and own element.
            always_comb begin
                if (do_bcast) opnd[j*LANE_W +: LANE_W] = src_vec[LANE_W-1:0];
                else          opnd[j*LANE_W +: LANE_W] = src_vec[j*LANE_W +: LANE_W];
            end
        end
    endgenerate

endmodule

// File: rtl/vlw_lane_policy.sv
// Module: vlw_lane_policy
// Turns the mask controls into a per-lane enable for the compute
// lanes and a disposition code for the merge stage.
// Assumes: combinational; mask_en low means every lane is written.
module vlw_lane_policy #(
    parameter int LANES = vlw_pkg::DEF_LANES
) (
    input  logic [LANES-1:0]                 wmask,
    input  logic                             mask_en,
    input  logic                             zero_mode,
    output logic [LANES-1:0]                 lane_en,
    output logic [LANES*vlw_pkg::DISP_W-1:0] disp_flat
);
    import vlw_pkg::*;

    genvar j;
    generate
        for (j = 0; j < LANES; j++) begin : g_lane
            lane_disp_e disp;

            // Lane is active when it will take its computed result.
            always_comb lane_en[j] = ~mask_en | wmask[j];

            // Choose result, keep or clear for this lane.
            always_comb begin
                if (lane_en[j])     disp = LD_RESULT;
                else if (zero_mode) disp = LD_CLEAR;
                else                disp = LD_KEEP;
            end

            // Flatten the code onto the port.
            always_comb disp_flat[j*DISP_W +: DISP_W] = disp;
        end
    endgenerate

endmodule

// File: rtl/vlw_lane_merge.sv
// Module: vlw_lane_merge
// Builds the next destination word of each lane from its disposition:
// computed result, old destination value, or zero.
// Assumes: combinational; the caller registers the output.
module vlw_lane_merge #(
    parameter int LANES  = vlw_pkg::DEF_LANES,
    parameter int LANE_W = vlw_pkg::DEF_LANE_W
) (
    input  logic [LANES*LANE_W-1:0]          lane_res,
    input  logic [LANES*LANE_W-1:0]          old_dst,
    input  logic [LANES*vlw_pkg::DISP_W-1:0] disp_flat,
    output logic [LANES*LANE_W-1:0]          merged
);
    import vlw_pkg::*;

    genvar j;
    generate
        for (j = 0; j < LANES; j++) begin : g_lane
            lane_disp_e disp;

            // Recover the enum code for this lane.
            always_comb disp = lane_disp_e'(disp_flat[j*DISP_W +: DISP_W]);

            // Per-lane word select.
            always_comb begin
                case (disp)
                    LD_RESULT: merged[j*LANE_W +: LANE_W] = lane_res[j*LANE_W +: LANE_W];
                    LD_KEEP:   merged[j*LANE_W +: LANE_W] = old_dst[j*LANE_W +: LANE_W];
                    default:   merged[j*LANE_W +: LANE_W] = '0;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/vlw_exc_reduce.sv
// Module: vlw_exc_reduce
// ORs each exception type over the enabled lanes only.
// Assumes: lane_exc bit EXC_TYPES*j+k is flag k of lane j.
module vlw_exc_reduce #(
    parameter int LANES     = vlw_pkg::DEF_LANES,
    parameter int EXC_TYPES = vlw_pkg::DEF_EXC_TYPES
) (
    input  logic [LANES*EXC_TYPES-1:0] lane_exc,
    input  logic [LANES-1:0]           lane_en,
    output logic [EXC_TYPES-1:0]       exc_any
);

    genvar k;
    generate
        for (k = 0; k < EXC_TYPES; k++) begin : g_type
            logic [LANES-1:0] hits;

            // Gather flag k from every lane, gated by that lane's enable.
            always_comb begin
                for (int j = 0; j < LANES; j++)
                    hits[j] = lane_exc[j*EXC_TYPES + k] & lane_en[j];
            end

            // Reduce to one summary bit.
            always_comb exc_any[k] = |hits;
        end
    endgenerate

endmodule

// File: rtl/vec_lane_writeback.sv
// Module: vec_lane_writeback (top)
// Steers operands to the compute lanes, enables only lanes that will be
// written, and on a result-valid cycle registers the masked merge of the
// lane results plus the summary exception flags.
// Assumes: synchronous active-low reset; all lanes update together.
module vec_lane_writeback #(
    parameter int LANES     = vlw_pkg::DEF_LANES,
    parameter int LANE_W    = vlw_pkg::DEF_LANE_W,
    parameter int EXC_TYPES = vlw_pkg::DEF_EXC_TYPES
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LANES*LANE_W-1:0]     src_vec,
    input  logic                        src_is_mem,
    input  logic                        bcast_en,
    input  logic [LANES-1:0]            wmask,
    input  logic                        mask_en,
    input  logic                        zero_mode,
    input  logic [LANES*LANE_W-1:0]     old_dst,
    input  logic                        res_valid,
    input  logic [LANES*LANE_W-1:0]     lane_res,
    input  logic [LANES*EXC_TYPES-1:0]  lane_exc,
    output logic [LANES*LANE_W-1:0]     lane_opnd,
    output logic [LANES-1:0]            lane_en,
    output logic [LANES*LANE_W-1:0]     dst_out,
    output logic [EXC_TYPES-1:0]        exc_sum
);
    localparam int VEC_W = LANES * LANE_W;

    logic [LANES*vlw_pkg::DISP_W-1:0] disp_flat;
    logic [VEC_W-1:0]                 merged;
    logic [EXC_TYPES-1:0]             exc_any;
    logic [VEC_W-1:0]                 dst_q;
    logic [EXC_TYPES-1:0]             exc_q;

    vlw_operand_steer #(.LANES(LANES), .LANE_W(LANE_W)) u_steer (
        .src_vec    (src_vec),
        .src_is_mem (src_is_mem),
        .bcast_en   (bcast_en),
        .opnd       (lane_opnd)
    );

    vlw_lane_policy #(.LANES(LANES)) u_policy (
        .wmask      (wmask),
        .mask_en    (mask_en),
        .zero_mode  (zero_mode),
        .lane_en    (lane_en),
        .disp_flat  (disp_flat)
    );

    vlw_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
        .lane_res   (lane_res),
        .old_dst    (old_dst),
        .disp_flat  (disp_flat),
        .merged     (merged)
    );

    vlw_exc_reduce #(.LANES(LANES), .EXC_TYPES(EXC_TYPES)) u_exc (
        .lane_exc   (lane_exc),
        .lane_en    (lane_en),
        .exc_any    (exc_any)
    );

    // Output register: load all lanes and flags together on res_valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_q <= '0;
            exc_q <= '0;
        end else if (res_valid) begin
            dst_q <= merged;
            exc_q <= exc_any;
        end
    end

    assign dst_out = dst_q;
    assign exc_sum = exc_q;

    // ---------------- assertions ----------------
    p_reset_clear_r11: assert property (@(posedge clk)
        !rst_n |=> (dst_out == '0 && exc_sum == '0));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> ($stable(dst_out) && $stable(exc_sum)));

    p_all_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_en |-> ($countones(lane_en) == LANES));

    p_no_exc_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && lane_en == '0) |=> (exc_sum == '0));

    genvar j;
    generate
        for (j = 0; j < LANES; j++) begin : g_chk
            p_take_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (res_valid && (!mask_en || wmask[j]))
                |=> dst_out[j*LANE_W +: LANE_W] == $past(lane_res[j*LANE_W +: LANE_W]));

            p_keep_old_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (res_valid && mask_en && !wmask[j] && !zero_mode)
                |=> dst_out[j*LANE_W +: LANE_W] == $past(old_dst[j*LANE_W +: LANE_W]));

            p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (res_valid && mask_en && !wmask[j] && zero_mode)
                |=> dst_out[j*LANE_W +: LANE_W] == '0);

            p_bcast_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (src_is_mem && bcast_en)
                |-> lane_opnd[j*LANE_W +: LANE_W] == lane_opnd[LANE_W-1:0]);
        end
    endgenerate

endmodule

// File: tb/sim_vec_lane_writeback.sv
module sim_vec_lane_writeback;
    localparam int CLK_P = 10;
    localparam int L = 16;
    localparam int W = 32;
    localparam int E = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [L*W-1:0] src_vec = '0, old_dst = '0, lane_res = '0;
    logic src_is_mem = 1'b0, bcast_en = 1'b0, mask_en = 1'b0, zero_mode = 1'b0, res_valid = 1'b0;
    logic [L-1:0] wmask = '0;
    logic [L*E-1:0] lane_exc = '0;
    logic [L*W-1:0] lane_opnd, dst_out;
    logic [L-1:0] lane_en;
    logic [E-1:0] exc_sum;

    always #(CLK_P/2) clk = ~clk;

    vec_lane_writeback #(.LANES(L), .LANE_W(W), .EXC_TYPES(E)) u0 (
        .clk(clk), .rst_n(rst_n), .src_vec(src_vec), .src_is_mem(src_is_mem),
        .bcast_en(bcast_en), .wmask(wmask), .mask_en(mask_en), .zero_mode(zero_mode),
        .old_dst(old_dst), .res_valid(res_valid), .lane_res(lane_res), .lane_exc(lane_exc),
        .lane_opnd(lane_opnd), .lane_en(lane_en), .dst_out(dst_out), .exc_sum(exc_sum)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference model state.
    logic [W-1:0] m_dst [L];
    logic [E-1:0] m_exc;
    string        m_tag [L];
    string        m_etag;
    bit           r1_pend;

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    // One cycle: check registered outputs, drive, check comb outputs, step model.
    task automatic cyc(input logic rst, input logic rv, input logic mem, input logic bc,
                       input logic me, input logic zm, input logic [L-1:0] mk,
                       input bit patterned);
        @(negedge clk);
        for (int j = 0; j < L; j++) chk(m_tag[j], 64'(dst_out[j*W +: W]), 64'(m_dst[j]));
        chk(m_etag, 64'(exc_sum), 64'(m_exc));
        if (r1_pend) begin
            for (int j = 0; j < L; j++)
                chk("R1", 64'(dst_out[j*W +: W]), 64'({8'hA5, 16'h0, 8'(j)}));
            r1_pend = 0;
        end
        rst_n = rst; res_valid = rv; src_is_mem = mem; bcast_en = bc;
        mask_en = me; zero_mode = zm; wmask = mk;
        for (int j = 0; j < L; j++) begin
            src_vec[j*W +: W]  = $urandom;
            old_dst[j*W +: W]  = $urandom;
            lane_res[j*W +: W] = patterned ? {8'hA5, 16'h0, 8'(j)} : $urandom;
        end
        lane_exc = $urandom;
        #1;
        for (int j = 0; j < L; j++) begin
            logic [W-1:0] eo;
            eo = (mem && bc) ? src_vec[W-1:0] : src_vec[j*W +: W];
            chk((!mem && bc) ? "R7" : "R6", 64'(lane_opnd[j*W +: W]), 64'(eo));
            chk("R8", 64'(lane_en[j]), 64'(!me || mk[j]));
        end
        if (!rst) begin
            for (int j = 0; j < L; j++) begin m_dst[j] = '0; m_tag[j] = "R11"; end
            m_exc = '0; m_etag = "R11";
        end else if (rv) begin
            m_exc = '0;
            for (int j = 0; j < L; j++) begin
                if (!me)        begin m_dst[j] = lane_res[j*W +: W]; m_tag[j] = "R2"; end
                else if (mk[j]) begin m_dst[j] = lane_res[j*W +: W]; m_tag[j] = "R3"; end
                else if (zm)    begin m_dst[j] = '0;                 m_tag[j] = "R5"; end
                else            begin m_dst[j] = old_dst[j*W +: W];  m_tag[j] = "R4"; end
                if (!me || mk[j])
                    for (int k = 0; k < E; k++) m_exc[k] = m_exc[k] | lane_exc[j*E + k];
            end
            m_etag = "R9";
            if (patterned && !me) r1_pend = 1;
        end else begin
            for (int j = 0; j < L; j++) m_tag[j] = "R10";
            m_etag = "R10";
        end
    endtask

    initial begin
        for (int j = 0; j < L; j++) begin m_dst[j] = '0; m_tag[j] = "R11"; end
        m_exc = '0; m_etag = "R11"; r1_pend = 0;
        @(posedge clk);
        cyc(0, 0, 0, 0, 0, 0, '0, 0);
        cyc(0, 1, 0, 0, 0, 0, '0, 0);
        // R1/R2: no mask, patterned results, mask bits ignored
        cyc(1, 1, 0, 0, 0, 1, 16'h1234, 1);
        // R3/R4: merge with half mask
        cyc(1, 1, 0, 0, 1, 0, 16'h00FF, 0);
        // R3/R5: zero with alternating mask
        cyc(1, 1, 0, 0, 1, 1, 16'hF0F0, 0);
        // R4/R9: empty mask merging, flags ignored
        cyc(1, 1, 0, 0, 1, 0, 16'h0000, 0);
        // R5/R9: empty mask zeroing
        cyc(1, 1, 0, 0, 1, 1, 16'h0000, 0);
        // R3: full mask
        cyc(1, 1, 0, 0, 1, 1, 16'hFFFF, 0);
        // R6: broadcast from memory
        cyc(1, 1, 1, 1, 1, 0, 16'hA5A5, 0);
        // R7: broadcast requested with register source
        cyc(1, 1, 0, 1, 0, 0, 16'h0000, 0);
        // R10: idle cycles hold
        cyc(1, 0, 1, 0, 1, 1, 16'h0F0F, 0);
        cyc(1, 0, 0, 0, 0, 0, 16'hFFFF, 0);
        // R11: reset mid-run
        cyc(0, 1, 0, 0, 0, 0, '0, 0);
        cyc(1, 1, 0, 0, 0, 0, '0, 0);
        for (int n = 0; n < 400; n++)
            cyc(1, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), 16'($urandom), 0);
        cyc(1, 0, 0, 0, 0, 0, '0, 0);
        cyc(1, 0, 0, 0, 0, 0, '0, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R10 act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule